// File: doc/BRIEF.md
# Burst Permission Gate with Deferred Write-Error Merge

This block sits between a DMA-style bus master and a system crossbar. For each transfer request it decides whether the master may issue the transfer as a burst or must fall back to single beats. The decision uses two inputs. The first is an enable bit for the address region, chosen by the three most significant address bits, so there are eight regions. The second is a global permission for the transfer's direction: one bit for reads and one for writes. All of these controls sit in one 32-bit control register, which software writes through a simple register port.

A granted write burst is carried out as two halves. The block acknowledges the first half to the FIFO side at once, with no error, so that the second half's data can be fetched before the first half has reached the bus. The real bus outcome of the first half arrives later. An accumulate control, sampled when the request is accepted, selects what happens to a first-half error. With the control clear, the error is dropped. With it set, the error is held and merged into the second half's response. The block tracks one write burst at a time and refuses new requests until that burst's second-half response has been delivered.

Top module: `burst_gate_top`

## Requirements
- R1: After reset the control register reads 0, `req_ready` is 1, and `dec_valid`, `fifo_h1_ack` and `fifo_h2_rsp_valid` are 0. A request made before any control write is never granted a burst.
- R2: Control register fields: bits [7:0] are the region enables (bit n serves address bits [31:29] = n), bit 8 is the read-burst enable, bit 9 is the write-burst enable and bit 10 is the accumulate control. A write loads these bits. Bits [31:11] ignore writes and read as 0.
- R3: A read request is granted a burst exactly when bit 8 is set and the region enable addressed by bits [31:29] is set.
- R4: A write request is granted a burst exactly when bit 9 is set and the region enable addressed by bits [31:29] is set.
- R5: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. In the following cycle `dec_valid` is 1 for one cycle, with `dec_burst` giving the grant and `dec_write` repeating the request's direction.
- R6: Controls are sampled at acceptance. A control write made in the same cycle as a request, or while a write burst is in flight, does not change that request's grant or that burst's accumulate behaviour.
- R7: `fifo_h1_ack` pulses in the same cycle as `dec_valid` for a granted write burst, before any first-half bus completion. It stays 0 for reads and for writes that are not granted.
- R8: With accumulate clear at acceptance, a first-half bus error is discarded and `fifo_h2_rsp_err` equals the second half's bus error.
- R9: With accumulate set at acceptance, `fifo_h2_rsp_err` is the OR of the first-half and second-half bus errors.
- R10: `fifo_h2_rsp_valid` pulses one cycle after `bus_h2_done`. Delivering that response clears the held first-half error, so it never carries over into a later burst.
- R11: `req_ready` is 0 from the acceptance of a granted write burst until its second-half response is delivered. A request presented while `req_ready` is 0 produces no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wdata | input | 32 | Control register write data |
| reg_rdata | output | 32 | Control register read value |
| req_valid | input | 1 | Transfer request present |
| req_write | input | 1 | Request direction, 1 = write |
| req_addr | input | 32 | Request address |
| req_ready | output | 1 | Block can accept a request |
| dec_valid | output | 1 | Decision valid, one cycle after acceptance |
| dec_burst | output | 1 | Burst granted |
| dec_write | output | 1 | Direction of the decided request |
| bus_h1_done | input | 1 | First half completed on the bus |
| bus_h1_err | input | 1 | First-half bus error |
| bus_h2_done | input | 1 | Second half completed on the bus |
| bus_h2_err | input | 1 | Second-half bus error |
| fifo_h1_ack | output | 1 | Early, error-free first-half acknowledge |
| fifo_h2_rsp_valid | output | 1 | Second-half response to the FIFO side |
| fifo_h2_rsp_err | output | 1 | Error flag of the second-half response |

## Verification
The grant is tested across all eight regions with sparse, alternating enable masks, with only the read enable set and with only the write enable set. This shows whether the region index is decoded correctly and whether the direction selects the right global bit. The error merge is driven with every combination of first-half and second-half errors under both accumulate settings. A clean burst that follows an error burst shows whether a held error leaks into the next transfer. Control writes placed in the request cycle and in the middle of a burst, together with requests placed while a burst is in flight, show whether values are sampled at acceptance and whether overlapping requests are refused.

// File: rtl/bg_pkg.sv
package bg_pkg;
  localparam int REGION_BITS = 3;
  localparam int NUM_REGIONS = 1 << REGION_BITS;
  localparam int RD_EN_POS   = NUM_REGIONS;
  localparam int WR_EN_POS   = NUM_REGIONS + 1;
  localparam int ACC_POS     = NUM_REGIONS + 2;
  localparam int CTRL_W      = NUM_REGIONS + 3;

  // packed MSB first: acc, wr_en, rd_en, region_en[NUM_REGIONS-1:0]
  typedef struct packed {
    logic                   acc;
    logic                   wr_en;
    logic                   rd_en;
    logic [NUM_REGIONS-1:0] region_en;
  } ctrl_t;

  typedef enum logic [1:0] {
    TRK_IDLE    = 2'd0,
    TRK_WAIT_H1 = 2'd1,
    TRK_WAIT_H2 = 2'd2
  } trk_state_e;
endpackage

// File: rtl/bg_ctrl_reg.sv
module bg_ctrl_reg
  import bg_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output ctrl_t            ctrl,
  output logic [REG_W-1:0] rdata
);
  localparam int PAD_W = REG_W - CTRL_W;

  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic  unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[REG_W-1:CTRL_W];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl  = ctrl_q;
  assign rdata = {{PAD_W{1'b0}}, ctrl_q};

  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rdata[CTRL_W-1:0] == $past(wdata[CTRL_W-1:0])));

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rdata));
endmodule

// File: rtl/bg_burst_decide.sv
module bg_burst_decide
  import bg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   accept,
  input  logic                   req_write,
  input  logic [REGION_BITS-1:0] region,
  input  ctrl_t                  ctrl,
  output logic                   grant_c,
  output logic                   dec_valid,
  output logic                   dec_burst,
  output logic                   dec_write
);
  logic [NUM_REGIONS-1:0] region_hit;
  logic                   region_ok;
  logic                   dir_ok;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    assign region_hit[g] = (region == REGION_BITS'(g)) & ctrl.region_en[g];
  end

  assign region_ok = |region_hit;
  assign dir_ok    = req_write ? ctrl.wr_en : ctrl.rd_en;
  assign grant_c   = region_ok & dir_ok;

  logic valid_q, valid_d;
  logic burst_q, burst_d;
  logic write_q, write_d;

  always_comb begin
    valid_d = accept;
    burst_d = burst_q;
    write_d = write_q;
    if (accept) begin
      burst_d = grant_c;
      write_d = req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      burst_q <= 1'b0;
      write_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      burst_q <= burst_d;
      write_q <= write_d;
    end
  end

  assign dec_valid = valid_q;
  assign dec_burst = burst_q;
  assign dec_write = write_q;

  // R5
  dec_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(accept));

  // R5
  dec_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> dec_valid && (dec_write == $past(req_write)));

  // R3
  rd_burst_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_burst && !dec_write) |-> $past(ctrl.rd_en));

  // R4
  wr_burst_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_burst && dec_write) |-> $past(ctrl.wr_en));
endmodule

// File: rtl/bg_err_track.sv
module bg_err_track
  import bg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic acc_in,
  input  logic bus_h1_done,
  input  logic bus_h1_err,
  input  logic bus_h2_done,
  input  logic bus_h2_err,
  output logic idle,
  output logic h1_ack,
  output logic h2_rsp_valid,
  output logic h2_rsp_err
);
  trk_state_e state_q, state_d;
  logic acc_q, acc_d;
  logic pend_q, pend_d;
  logic h1_q, h1_d;
  logic rv_q, rv_d;
  logic re_q, re_d;

  always_comb begin
    state_d = state_q;
    acc_d   = acc_q;
    pend_d  = pend_q;
    h1_d    = 1'b0;
    rv_d    = 1'b0;
    re_d    = 1'b0;
    case (state_q)
      TRK_IDLE: begin
        if (start) begin
          state_d = TRK_WAIT_H1;
          acc_d   = acc_in;
          pend_d  = 1'b0;
          h1_d    = 1'b1;
        end
      end
      TRK_WAIT_H1: begin
        if (bus_h1_done) begin
          pend_d  = acc_q & bus_h1_err;
          state_d = TRK_WAIT_H2;
        end
      end
      TRK_WAIT_H2: begin
        if (bus_h2_done) begin
          rv_d    = 1'b1;
          re_d    = bus_h2_err | pend_q;
          pend_d  = 1'b0;
          state_d = TRK_IDLE;
        end
      end
      default: state_d = TRK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TRK_IDLE;
      acc_q   <= 1'b0;
      pend_q  <= 1'b0;
      h1_q    <= 1'b0;
      rv_q    <= 1'b0;
      re_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      acc_q   <= acc_d;
      pend_q  <= pend_d;
      h1_q    <= h1_d;
      rv_q    <= rv_d;
      re_q    <= re_d;
    end
  end

  assign idle         = (state_q == TRK_IDLE);
  assign h1_ack       = h1_q;
  assign h2_rsp_valid = rv_q;
  assign h2_rsp_err   = re_q;

  // R7
  early_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h1_ack |-> $past(start) && (state_q == TRK_WAIT_H1));

  // R6
  acc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != TRK_IDLE && $past(state_q != TRK_IDLE)) |-> $stable(acc_q));

  // R8
  drop_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TRK_WAIT_H1 && bus_h1_done && !acc_q) |=> !pend_q);

  // R9
  merge_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TRK_WAIT_H2 && bus_h2_done && pend_q) |=> (h2_rsp_valid && h2_rsp_err));

  // R10
  pend_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h2_rsp_valid |-> (!pend_q && idle));

  // R10
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h2_rsp_valid |-> $past(bus_h2_done));

  // R7
  ack_rsp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({h1_ack, h2_rsp_valid}));
endmodule

// File: rtl/burst_gate_top.sv
module burst_gate_top
  import bg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              dec_valid,
  output logic              dec_burst,
  output logic              dec_write,
  input  logic              bus_h1_done,
  input  logic              bus_h1_err,
  input  logic              bus_h2_done,
  input  logic              bus_h2_err,
  output logic              fifo_h1_ack,
  output logic              fifo_h2_rsp_valid,
  output logic              fifo_h2_rsp_err
);
  localparam int REGION_LSB = ADDR_W - REGION_BITS;

  ctrl_t                  ctrl;
  logic                   accept;
  logic                   grant_c;
  logic                   start;
  logic                   trk_idle;
  logic [REGION_BITS-1:0] region;
  logic                   unused_addr_lo;

  assign region         = req_addr[ADDR_W-1:REGION_LSB];
  assign unused_addr_lo = ^req_addr[REGION_LSB-1:0];
  assign req_ready      = trk_idle;
  assign accept         = req_valid & req_ready;
  assign start          = accept & req_write & grant_c;

  bg_ctrl_reg #(.REG_W(REG_W)) i_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr_en),
    .wdata (reg_wdata),
    .ctrl  (ctrl),
    .rdata (reg_rdata)
  );

  bg_burst_decide i_decide (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_write (req_write),
    .region    (region),
    .ctrl      (ctrl),
    .grant_c   (grant_c),
    .dec_valid (dec_valid),
    .dec_burst (dec_burst),
    .dec_write (dec_write)
  );

  bg_err_track i_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .acc_in       (ctrl.acc),
    .bus_h1_done  (bus_h1_done),
    .bus_h1_err   (bus_h1_err),
    .bus_h2_done  (bus_h2_done),
    .bus_h2_err   (bus_h2_err),
    .idle         (trk_idle),
    .h1_ack       (fifo_h1_ack),
    .h2_rsp_valid (fifo_h2_rsp_valid),
    .h2_rsp_err   (fifo_h2_rsp_err)
  );

  // R11
  refuse_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> !dec_valid);

  // R7
  ack_only_write_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_h1_ack |-> (dec_valid && dec_burst && dec_write));

  // R11
  busy_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_h1_ack |-> !req_ready);
endmodule

// File: tb/test_burst_gate_top.sv
`timescale 1ns/1ps
module test_burst_gate_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        req_valid;
  logic        req_write;
  logic [31:0] req_addr;
  logic        req_ready;
  logic        dec_valid, dec_burst, dec_write;
  logic        bus_h1_done, bus_h1_err, bus_h2_done, bus_h2_err;
  logic        fifo_h1_ack, fifo_h2_rsp_valid, fifo_h2_rsp_err;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] shadow = '0;

  logic [2:0] dec_q[$];   // {burst, write, h1_ack}
  logic       rsp_q[$];   // expected error flag

  always #4 clk = ~clk;

  burst_gate_top i_burst_gate_top (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_ready(req_ready),
    .dec_valid(dec_valid), .dec_burst(dec_burst), .dec_write(dec_write),
    .bus_h1_done(bus_h1_done), .bus_h1_err(bus_h1_err),
    .bus_h2_done(bus_h2_done), .bus_h2_err(bus_h2_err),
    .fifo_h1_ack(fifo_h1_ack), .fifo_h2_rsp_valid(fifo_h2_rsp_valid),
    .fifo_h2_rsp_err(fifo_h2_rsp_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic grant_of(input logic [31:0] c, input logic w, input logic [31:0] a);
    return c[a[31:29]] & (w ? c[9] : c[8]);
  endfunction

  // monitor: compares decisions and second-half responses
  always @(negedge clk) begin
    if (rst_n) begin
      if (dec_valid) begin
        if (dec_q.size() == 0) check("R11 unexpected decision", 32'd1, 32'd0);
        else check("R3/R4/R5/R7 decision {burst,write,h1ack}",
                   {29'd0, dec_burst, dec_write, fifo_h1_ack}, {29'd0, dec_q.pop_front()});
      end else if (fifo_h1_ack) begin
        check("R7 h1 ack without decision", 32'd1, 32'd0);
      end
      if (fifo_h2_rsp_valid) begin
        if (rsp_q.size() == 0) check("R10 unexpected h2 response", 32'd1, 32'd0);
        else check("R8/R9/R10 h2 response err", {31'd0, fifo_h2_rsp_err}, {31'd0, rsp_q.pop_front()});
      end
    end
  end

  task automatic wr_ctrl(input logic [31:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_wr_en = 1'b0;
    shadow = v & 32'h0000_07FF;
  endtask

  // one request; a granted write burst runs both halves.
  // mid_mode: 0 none, 1 control write in request cycle, 2 control write during first half
  task automatic xfer(input logic w, input logic [31:0] a, input logic e1, input logic e2,
                      input int mid_mode, input logic [31:0] mid_val, input logic intrude);
    logic g;
    g = grant_of(shadow, w, a);
    @(negedge clk);
    check("R11 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1;
    req_write = w;
    req_addr  = a;
    if (mid_mode == 1) begin
      reg_wr_en = 1'b1;
      reg_wdata = mid_val;
    end
    dec_q.push_back({g, w, g & w});
    if (g & w) rsp_q.push_back(e2 | (shadow[10] & e1));
    @(negedge clk);
    req_valid = 1'b0;
    reg_wr_en = 1'b0;
    if (mid_mode == 1) shadow = mid_val & 32'h0000_07FF;
    if (g & w) begin
      check("R11 ready low during burst", {31'd0, req_ready}, 32'd0);
      bus_h1_done = 1'b1;
      bus_h1_err  = e1;
      if (mid_mode == 2) begin
        reg_wr_en = 1'b1;
        reg_wdata = mid_val;
      end
      if (intrude) begin
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = 32'h0000_0000;
      end
      @(negedge clk);
      bus_h1_done = 1'b0;
      bus_h1_err  = 1'b0;
      reg_wr_en   = 1'b0;
      req_valid   = 1'b0;
      if (mid_mode == 2) shadow = mid_val & 32'h0000_07FF;
      bus_h2_done = 1'b1;
      bus_h2_err  = e2;
      @(negedge clk);
      bus_h2_done = 1'b0;
      bus_h2_err  = 1'b0;
      @(negedge clk);
      check("R11 ready restored", {31'd0, req_ready}, 32'd1);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    reg_wr_en = 1'b0; reg_wdata = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    bus_h1_done = 1'b0; bus_h1_err = 1'b0; bus_h2_done = 1'b0; bus_h2_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rdata after reset", reg_rdata, 32'd0);
    check("R1 ready after reset", {31'd0, req_ready}, 32'd1);
    check("R1 outputs idle", {29'd0, dec_valid, fifo_h1_ack, fifo_h2_rsp_valid}, 32'd0);
    xfer(1'b0, 32'h0000_0100, 1'b0, 1'b0, 0, '0, 1'b0);
    xfer(1'b1, 32'hE000_0000, 1'b0, 1'b0, 0, '0, 1'b0);

    // R2 field layout, reserved bits
    wr_ctrl(32'hFFFF_FFFF);
    check("R2 reserved bits read zero", reg_rdata, 32'h0000_07FF);
    wr_ctrl(32'hABCD_F2A5);
    check("R2 pattern readback", reg_rdata, 32'h0000_02A5);

    // R3 read sweep, sparse mask, only read enable
    wr_ctrl(32'h0000_01A5);
    for (int r = 0; r < 8; r++) xfer(1'b0, {r[2:0], 29'h0000_1234}, 1'b0, 1'b0, 0, '0, 1'b0);
    // R4 writes refused without write enable
    for (int r = 0; r < 8; r++) xfer(1'b1, {r[2:0], 29'h0}, 1'b0, 1'b0, 0, '0, 1'b0);

    // R4 write sweep, alternating mask, only write enable
    wr_ctrl(32'h0000_025A);
    for (int r = 0; r < 8; r++) xfer(1'b1, {r[2:0], 29'h0000_0040}, 1'b0, 1'b0, 0, '0, 1'b0);
    // R3 reads refused without read enable
    for (int r = 0; r < 8; r++) xfer(1'b0, {r[2:0], 29'h0}, 1'b0, 1'b0, 0, '0, 1'b0);

    // R8 accumulate clear: first-half error discarded
    wr_ctrl(32'h0000_03FF);
    xfer(1'b1, 32'h2000_0000, 1'b1, 1'b0, 0, '0, 1'b0);
    xfer(1'b1, 32'h2000_0000, 1'b1, 1'b1, 0, '0, 1'b0);
    xfer(1'b1, 32'h2000_0000, 1'b0, 1'b1, 0, '0, 1'b0);

    // R9 accumulate set: errors merged
    wr_ctrl(32'h0000_07FF);
    xfer(1'b1, 32'h4000_0000, 1'b1, 1'b0, 0, '0, 1'b0);
    // R10 held error does not leak into next burst
    xfer(1'b1, 32'h4000_0000, 1'b0, 1'b0, 0, '0, 1'b0);
    xfer(1'b1, 32'h6000_0000, 1'b0, 1'b1, 0, '0, 1'b0);
    xfer(1'b1, 32'h6000_0000, 1'b1, 1'b1, 0, '0, 1'b0);
    xfer(1'b1, 32'h6000_0000, 1'b0, 1'b0, 0, '0, 1'b0);

    // R6 control write in the request cycle: old enables apply
    xfer(1'b1, 32'h8000_0000, 1'b0, 1'b0, 1, 32'h0000_0000, 1'b0);
    xfer(1'b1, 32'h8000_0000, 1'b0, 1'b0, 0, '0, 1'b0);
    wr_ctrl(32'h0000_07FF);
    // R6 accumulate cleared mid-burst: still merged
    xfer(1'b1, 32'hA000_0000, 1'b1, 1'b0, 2, 32'h0000_03FF, 1'b0);
    // R6 accumulate set mid-burst: still dropped
    xfer(1'b1, 32'hA000_0000, 1'b1, 1'b0, 2, 32'h0000_07FF, 1'b0);

    // R11 request during a burst is refused
    xfer(1'b1, 32'hC000_0000, 1'b0, 1'b0, 0, '0, 1'b1);
    xfer(1'b0, 32'hC000_0000, 1'b0, 1'b0, 0, '0, 1'b0);

    repeat (3) @(negedge clk);
    check("R5 no decisions left outstanding", dec_q.size(), 32'd0);
    check("R10 no responses left outstanding", rsp_q.size(), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule